// File: doc/BRIEF.md
# IN Endpoint Shutdown and Transmit FIFO Flush Controller

This block holds the control state of a set of device-side IN endpoints and carries out the orderly stop of their transfers, for instance after the host resets the bus. Software writes single-cycle commands through a plain register write port. It can enable an endpoint, ask for it to be disabled, acknowledge interrupt flags, set an interrupt mask, and start a flush of one transmit FIFO. Every IN endpoint, endpoint 0 included, follows the same disable handshake. Once a disable is requested, no new packet may start. Any packet already in flight is allowed to finish. The hardware then drops the enable and the request together and raises a per-endpoint "disabled" flag.

Each transmit FIFO is modelled by an occupancy counter with push and pop strobes. A flush selects one FIFO by number and drains it one word per cycle. The flush command reports busy until the selected FIFO is seen to be empty, and then clears itself. A flush aimed at an endpoint that is still enabled waits until that endpoint is disabled. A FIFO number with no FIFO behind it finishes at once.

Top module: `inep_shutdown_ctl`

## Requirements
- R1: After a synchronous reset, all enable, disable-pending, transmit-allow and interrupt bits are 0, `irq` and `flush_busy` are 0, and every FIFO reads empty.
- R2: A write to address e (0 to NUM_EP-1) sets endpoint e's enable when data bit 0 is 1, and sets its disable request when data bit 1 is 1. The enable bit is ignored if a disable request is already pending or arrives in the same write.
- R3: `tx_allow[e]` is 1 exactly when endpoint e is enabled and has no disable pending, so no new packet can start once a disable has been requested.
- R4: A pending disable completes at the first clock edge at which the endpoint is not enabled or its `tx_busy` input is 0. While the endpoint is enabled and `tx_busy` is 1, the request stays pending. Endpoint 0 behaves the same as the others.
- R5: At the edge where a disable completes, the endpoint's enable and disable-pending bits both clear and its interrupt flag sets. For a disabled endpoint, this happens one cycle after the request is written.
- R6: Writing to address NUM_EP clears each interrupt flag whose data bit is 1. If a clear and a completion hit the same flag in the same cycle, the flag ends up set.
- R7: A write to address NUM_EP+1 loads the per-endpoint mask from the data bits. `irq` is 1 when any flag is set and its mask bit is 1, and it changes in the same cycle as the flags and the mask.
- R8: A write to address NUM_EP+2 with data bit 0 set starts a flush of the FIFO numbered by data bits FNUM_W:1, and `flush_busy` reads 1 after that write. A flush write while `flush_busy` is 1 is ignored.
- R9: A flush of a FIFO holding L words, on a disabled endpoint, removes one word per cycle. `flush_busy` stays 1 for L+1 cycles, and the FIFO reads empty before `flush_busy` falls.
- R10: While the endpoint that owns the selected FIFO is enabled, the flush removes nothing and `flush_busy` stays 1. Draining starts in the cycle after the enable clears.
- R11: A flush whose FIFO number is NUM_EP or above keeps `flush_busy` at 1 for exactly one cycle.
- R12: Each FIFO level rises by one on a push when not full (DEPTH words) and falls by one on a pop when not empty. A push together with a pop leaves it unchanged. A push or pop to the FIFO under flush is ignored. `fifo_empty` shows a level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tx_busy | input | NUM_EP | Per-endpoint packet-in-flight indication |
| fifo_push | input | NUM_EP | Per-FIFO word push strobe |
| fifo_pop | input | NUM_EP | Per-FIFO word pop strobe |
| ep_enabled | output | NUM_EP | Endpoint enable bits |
| ep_dis_pend | output | NUM_EP | Pending disable request bits |
| tx_allow | output | NUM_EP | New packet may start |
| ep_int | output | NUM_EP | Endpoint-disabled interrupt flags |
| flush_busy | output | 1 | Flush command in progress |
| fifo_empty | output | NUM_EP | FIFO level is zero |
| irq | output | 1 | Masked OR of the interrupt flags |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a software clear of an endpoint's interrupt flag and the hardware completion that sets the same flag. The bench provokes this by lowering `tx_busy` and issuing the clear write at the same edge, and it expects the flag to stay set. The second pair is the end of a disable and a flush that is waiting on that endpoint. For this case the bench times `flush_busy` from the cycle the enable falls and expects exactly L+1 busy cycles. A write that lands on the completion edge of a disable is also checked: the enable it carries must be dropped.

// File: rtl/inep_pkg.sv
package inep_pkg;
  // control write bit positions
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_DIS_BIT = 1;
  // flush command bit positions
  localparam int FL_GO_BIT   = 0;
  localparam int FL_NUM_LSB  = 1;
endpackage

// File: rtl/inep_ep_ctrl.sv
module inep_ep_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic set_en,
  input  logic set_dis,
  input  logic tx_busy,
  output logic en_q,
  output logic dis_q,
  output logic allow_q,
  output logic done
);
  logic en_n, dis_n;

  // finish when nothing can still be on the wire
  assign done = dis_q && (!en_q || !tx_busy);

  always_comb begin
    en_n  = en_q;
    dis_n = dis_q;
    if (done) begin
      en_n  = 1'b0;
      dis_n = 1'b0;
    end else if (ctl_we) begin
      if (set_dis) dis_n = 1'b1;
      if (set_en && !set_dis && !dis_q) en_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      dis_q   <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      en_q    <= en_n;
      dis_q   <= dis_n;
      allow_q <= en_n && !dis_n;
    end
  end
endmodule

// File: rtl/inep_fifo_occ.sv
module inep_fifo_occ #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic drain,
  output logic empty_q
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_q, lvl_n;

  always_comb begin
    lvl_n = lvl_q;
    if (drain) begin
      if (lvl_q != '0) lvl_n = lvl_q - 1'b1;
    end else if (push && !pop && lvl_q != FULL_LVL) begin
      lvl_n = lvl_q + 1'b1;
    end else if (pop && !push && lvl_q != '0) begin
      lvl_n = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      lvl_q   <= lvl_n;
      empty_q <= (lvl_n == '0);
    end
  end
endmodule

// File: rtl/inep_flush_seq.sv
module inep_flush_seq #(
  parameter int NUM_EP = 4,
  parameter int FNUM_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FNUM_W-1:0] start_num,
  input  logic [NUM_EP-1:0] ep_en,
  input  logic [NUM_EP-1:0] fifo_empty,
  output logic              busy_q,
  output logic [FNUM_W-1:0] num_q,
  output logic [NUM_EP-1:0] own,
  output logic [NUM_EP-1:0] drain
);
  logic sel_valid, sel_en, sel_empty;

  always_comb begin
    sel_valid = 1'b0;
    sel_en    = 1'b0;
    sel_empty = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      own[i] = busy_q && (num_q == FNUM_W'(i));
      if (num_q == FNUM_W'(i)) begin
        sel_valid = 1'b1;
        sel_en    = ep_en[i];
        sel_empty = fifo_empty[i];
      end
    end
    for (int i = 0; i < NUM_EP; i++) begin
      drain[i] = own[i] && !sel_en && !sel_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      num_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        num_q  <= start_num;
      end
    end else if (!sel_valid) begin
      busy_q <= 1'b0;
    end else if (!sel_en && sel_empty) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/inep_irq.sv
module inep_irq #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] set,
  input  logic              clr_we,
  input  logic [NUM_EP-1:0] clr_bits,
  input  logic              mask_we,
  input  logic [NUM_EP-1:0] mask_bits,
  output logic [NUM_EP-1:0] int_q,
  output logic [NUM_EP-1:0] mask_q,
  output logic              irq_q
);
  logic [NUM_EP-1:0] int_n, mask_n;

  always_comb begin
    int_n  = (int_q & ~(clr_we ? clr_bits : '0)) | set;
    mask_n = mask_we ? mask_bits : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      int_q  <= int_n;
      mask_q <= mask_n;
      irq_q  <= |(int_n & mask_n);
    end
  end
endmodule

// File: rtl/inep_shutdown_ctl.sv
module inep_shutdown_ctl
  import inep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 16,
  parameter int FNUM_W = 5,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_EP-1:0] tx_busy,
  input  logic [NUM_EP-1:0] fifo_push,
  input  logic [NUM_EP-1:0] fifo_pop,
  output logic [NUM_EP-1:0] ep_enabled,
  output logic [NUM_EP-1:0] ep_dis_pend,
  output logic [NUM_EP-1:0] tx_allow,
  output logic [NUM_EP-1:0] ep_int,
  output logic              flush_busy,
  output logic [NUM_EP-1:0] fifo_empty,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_INTCLR = ADDR_W'(NUM_EP);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(NUM_EP + 1);
  localparam logic [ADDR_W-1:0] A_FLUSH  = ADDR_W'(NUM_EP + 2);

  logic [NUM_EP-1:0] ctl_sel, ep_done, fl_own, fl_drain;
  logic [FNUM_W-1:0] fl_num;
  logic              clr_we, mask_we, flush_we;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      ctl_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
    clr_we   = wr_en && (wr_addr == A_INTCLR);
    mask_we  = wr_en && (wr_addr == A_MASK);
    flush_we = wr_en && (wr_addr == A_FLUSH) && wr_data[FL_GO_BIT];
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    inep_ep_ctrl u_ep (
      .clk    (clk),
      .rst    (rst),
      .ctl_we (ctl_sel[g]),
      .set_en (wr_data[CTL_EN_BIT]),
      .set_dis(wr_data[CTL_DIS_BIT]),
      .tx_busy(tx_busy[g]),
      .en_q   (ep_enabled[g]),
      .dis_q  (ep_dis_pend[g]),
      .allow_q(tx_allow[g]),
      .done   (ep_done[g])
    );

    inep_fifo_occ #(.DEPTH(DEPTH)) u_occ (
      .clk    (clk),
      .rst    (rst),
      .push   (fifo_push[g] && !fl_own[g]),
      .pop    (fifo_pop[g] && !fl_own[g]),
      .drain  (fl_drain[g]),
      .empty_q(fifo_empty[g])
    );
  end

  inep_flush_seq #(.NUM_EP(NUM_EP), .FNUM_W(FNUM_W)) u_flush (
    .clk       (clk),
    .rst       (rst),
    .start     (flush_we),
    .start_num (wr_data[FL_NUM_LSB +: FNUM_W]),
    .ep_en     (ep_enabled),
    .fifo_empty(fifo_empty),
    .busy_q    (flush_busy),
    .num_q     (fl_num),
    .own       (fl_own),
    .drain     (fl_drain)
  );

  logic [NUM_EP-1:0] mask_unused;

  inep_irq #(.NUM_EP(NUM_EP)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set      (ep_done),
    .clr_we   (clr_we),
    .clr_bits (wr_data[NUM_EP-1:0]),
    .mask_we  (mask_we),
    .mask_bits(wr_data[NUM_EP-1:0]),
    .int_q    (ep_int),
    .mask_q   (mask_unused),
    .irq_q    (irq)
  );
endmodule

// File: rtl/inep_shutdown_chk.sv
module inep_shutdown_chk #(
  parameter int NUM_EP = 4,
  parameter int FNUM_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EP-1:0] tx_busy,
  input logic [NUM_EP-1:0] en,
  input logic [NUM_EP-1:0] dis,
  input logic [NUM_EP-1:0] allow,
  input logic [NUM_EP-1:0] intf,
  input logic              fbusy,
  input logic [FNUM_W-1:0] fnum,
  input logic [NUM_EP-1:0] fempty
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    a_r3_allow_gated: assert property (@(posedge clk) disable iff (rst)
      allow[i] |-> (en[i] && !dis[i]));

    a_r4_hold_in_flight: assert property (@(posedge clk) disable iff (rst)
      (en[i] && dis[i] && tx_busy[i]) |=> dis[i]);

    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
      dis[i] |=> (dis[i] || (intf[i] && !en[i])));

    a_r10_wait_enabled: assert property (@(posedge clk) disable iff (rst)
      (fbusy && fnum == FNUM_W'(i) && en[i]) |=> fbusy);

    a_r9_empty_at_end: assert property (@(posedge clk) disable iff (rst)
      ($fell(fbusy) && $past(fnum) == FNUM_W'(i)) |-> fempty[i]);
  end
endmodule

bind inep_shutdown_ctl inep_shutdown_chk #(.NUM_EP(NUM_EP), .FNUM_W(FNUM_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tx_busy(tx_busy),
  .en    (ep_enabled),
  .dis   (ep_dis_pend),
  .allow (tx_allow),
  .intf  (ep_int),
  .fbusy (flush_busy),
  .fnum  (fl_num),
  .fempty(fifo_empty)
);

// File: tb/sim_inep_shutdown_ctl.sv
`timescale 1ns/1ps
module sim_inep_shutdown_ctl;
  localparam int N  = 4;
  localparam int D  = 8;
  localparam int FW = 3;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0] tx_busy = '0, fifo_push = '0, fifo_pop = '0;
  logic [N-1:0] ep_enabled, ep_dis_pend, tx_allow, ep_int, fifo_empty;
  logic flush_busy, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  inep_shutdown_ctl #(.NUM_EP(N), .DEPTH(D), .FNUM_W(FW), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_busy(tx_busy), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .ep_enabled(ep_enabled), .ep_dis_pend(ep_dis_pend), .tx_allow(tx_allow),
    .ep_int(ep_int), .flush_busy(flush_busy), .fifo_empty(fifo_empty), .irq(irq)
  );

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_n(int f, int n);
    for (int k = 0; k < n; k++) begin
      fifo_push[f] = 1'b1;
      step();
    end
    fifo_push[f] = 1'b0;
  endtask

  // counts cycles with flush_busy high after the command
  task automatic flush_len(int f, output int len);
    wr(N + 2, (f << 1) | 1);
    len = 0;
    while (flush_busy && len < 100) begin
      len++;
      step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int len;
    step(3);
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 enabled", ep_enabled, 0);
    check("R1 pending", ep_dis_pend, 0);
    check("R1 allow", tx_allow, 0);
    check("R1 int", ep_int, 0);
    check("R1 busy", flush_busy, 0);
    check("R1 irq", irq, 0);
    check("R1 empty", fifo_empty, (1 << N) - 1);

    // per-endpoint shutdown with a flush waiting on it
    for (int e = 0; e < N; e++) begin
      wr(e, 1);
      check("R2 enable set", ep_enabled[e], 1);
      check("R3 allow on", tx_allow[e], 1);
      push_n(e, e + 2);
      check("R12 not empty", fifo_empty[e], 0);
      wr(N + 2, (e << 1) | 1);
      check("R8 busy after write", flush_busy, 1);
      step(3);
      check("R10 waiting busy", flush_busy, 1);
      check("R10 no drain", fifo_empty[e], 0);
      tx_busy[e] = 1'b1;
      wr(e, 2);
      check("R3 allow off", tx_allow[e], 0);
      step(e + 1);
      check("R4 held pending", ep_dis_pend[e], 1);
      check("R4 held enabled", ep_enabled[e], 1);
      check("R4 no int yet", ep_int[e], 0);
      tx_busy[e] = 1'b0;
      step();
      check("R5 enable cleared", ep_enabled[e], 0);
      check("R5 pending cleared", ep_dis_pend[e], 0);
      check("R5 int set", ep_int[e], 1);
      check("R7 masked irq", irq, 0);
      step(e + 2);
      check("R9 busy during drain", flush_busy, 1);
      check("R9 empty before end", fifo_empty[e], 1);
      step();
      check("R9 busy cleared", flush_busy, 0);
      wr(N, 1 << e);
      check("R6 int cleared", ep_int[e], 0);
    end

    // disable on a disabled endpoint, even with tx_busy high
    tx_busy[2] = 1'b1;
    wr(2, 2);
    check("R4 pending one cycle", ep_dis_pend[2], 1);
    step();
    check("R5 idle done int", ep_int[2], 1);
    check("R5 idle done pend", ep_dis_pend[2], 0);
    tx_busy[2] = 1'b0;
    wr(N + 1, 4'b0100);
    check("R7 irq unmasked", irq, 1);
    wr(N, 4'b0100);
    check("R7 irq after clear", irq, 0);
    check("R6 int2 cleared", ep_int[2], 0);

    // clear and completion in the same cycle: set wins
    wr(1, 2); step();
    check("R5 int1 set", ep_int[1], 1);
    wr(1, 1);
    tx_busy[1] = 1'b1;
    wr(1, 2);
    tx_busy[1] = 1'b0;
    wr(N, 4'b0010);
    check("R6 set wins", ep_int[1], 1);
    check("R5 enable cleared ep1", ep_enabled[1], 0);
    wr(N, 4'b0010);
    check("R6 cleared later", ep_int[1], 0);

    // enable ignored with a pending or same-write disable
    wr(3, 2);
    wr(3, 1);
    check("R2 enable dropped at done", ep_enabled[3], 0);
    check("R5 int3", ep_int[3], 1);
    wr(3, 3);
    check("R2 both bits no enable", ep_enabled[3], 0);
    step();
    check("R2 done after both", ep_dis_pend[3], 0);
    wr(N, 4'b1000);
    wr(0, 0);
    check("R2 zero write", ep_enabled[0], 0);

    // flush length sweep over every FIFO and several levels
    for (int f = 0; f < N; f++) begin
      for (int li = 0; li < 4; li++) begin
        int lv;
        lv = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : D;
        push_n(f, lv);
        flush_len(f, len);
        check($sformatf("R9 flush f%0d L%0d", f, lv), len, lv + 1);
      end
    end

    // out-of-range numbers
    for (int f = N; f < (1 << FW); f++) begin
      flush_len(f, len);
      check("R11 out of range", len, 1);
    end

    // second flush write while busy is ignored
    push_n(0, 3);
    wr(N + 2, 1);
    wr(N + 2, (5 << 1) | 1);
    check("R8 still busy", flush_busy, 1);
    step(2);
    check("R8 first flush runs", flush_busy, 1);
    step();
    check("R8 ends on schedule", flush_busy, 0);

    // overflow, pop on empty, push with pop
    push_n(3, D + 3);
    flush_len(3, len);
    check("R12 full limit", len, D + 1);
    fifo_pop[2] = 1'b1; step(3); fifo_pop[2] = 1'b0;
    push_n(2, 2);
    fifo_pop[2] = 1'b1; fifo_push[2] = 1'b1; step();
    fifo_push[2] = 1'b0; step(); fifo_pop[2] = 1'b0;
    flush_len(2, len);
    check("R12 pop empty push pop", len, 2);

    // pushes into the FIFO under flush are ignored
    push_n(1, 5);
    wr(N + 2, (1 << 1) | 1);
    fifo_push[1] = 1'b1;
    while (flush_busy) step();
    fifo_push[1] = 1'b0;
    check("R12 push blocked", fifo_empty[1], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule